// File: doc/BRIEF.md
# Byte-Wide Serial Port Register Bank

This block is the host-facing register set of a PC-style serial port. Eight byte registers sit at offsets 0 to 7. The host reaches them through a 3-bit address, a write strobe with write data and a read strobe with read data. Read data is combinational from the current address and state. Any side effect of a read (popping the receive queue, clearing interrupt identification) takes place on the clock edge where the read strobe is high.

A byte the host writes to the data register leaves on a one-cycle transmit strobe. An external agent offers received bytes on a valid/byte input pair. Those bytes go into a 64-entry receive queue, and the host drains that queue through the data register. The block keeps one interrupt-identification bit for each source, and a "nothing pending" code applies when no source bit is set. It emits a one-cycle interrupt pulse for each qualifying event.

A loopback mode sends host writes back into the receive queue. In this mode the transmit strobe stays low and the external input is ignored. The 16-bit baud divisor is only stored and read back, through offsets 0 and 1 while the bank-select bit of line control is set.

Top module: `serial_regbank`

## Requirements
- R1: After reset, reads return: offset 0 = 0x00 (queue empty), offset 1 = 0x00, offset 2 = 0xC1, offset 3 (line control) = 0x03, offset 4 (modem control) = 0x08, offset 5 (line status) = 0x60, offset 6 (modem status) = 0xB0, offset 7 (scratch) = 0x00. The divisor resets to 12.
- R2: While line-control bit 7 is 1, offset 0 reads and writes the low byte of the divisor and offset 1 its high byte. The data and interrupt-enable registers are left untouched.
- R3: A write to the interrupt-enable register (offset 1) stores only bits 3:0. Bits 7:4 always read as 0.
- R4: The identification register holds two source bits: 0x02 for transmit and 0x04 for receive. When neither bit is set it reads 0x01, and it reads 0x00 in bit 0 whenever either bit is set. A read of offset 2 returns the value ORed with 0xC0 and leaves the register at 0x01.
- R5: With loopback off (modem-control bit 4 = 0), a data write pulses txValid for one cycle with the byte. If interrupt-enable bit 1 is set, the write also sets identification bit 0x02 and pulses irqPulse.
- R6: Every byte that enters the receive queue sets line-status bit 0. If interrupt-enable bit 0 is set, it also sets identification bit 0x04 and pulses irqPulse.
- R7: A data read returns the oldest queued byte and pops it, or returns 0 if the queue is empty. It also clears identification bit 0x04. Line-status bit 0 falls once the last byte is popped.
- R8: With modem-control bit 4 set, a data write is queued for the host instead of transmitted, and txValid stays low. The write is dropped if the queue already holds 64 bytes.
- R9: While loopback is on, bytes on rxValid/rxByte are ignored.
- R10: rxFull is 1 exactly while the queue holds 64 bytes. An external byte offered then is dropped.
- R11: Writes to offsets 2, 5 and 6 have no effect.
- R12: Line control, modem control and scratch read back the value last written.
- R13: irqPulse is high for one cycle per event and low in the following cycle if no new event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register offset |
| wrEn | input | 1 | Host write strobe |
| wrData | input | 8 | Host write data |
| rdEn | input | 1 | Host read strobe (side effects on its edge) |
| rdData | output | 8 | Read data for regAddr |
| txValid | output | 1 | One-cycle strobe for a transmitted byte |
| txByte | output | 8 | Transmitted byte |
| rxValid | input | 1 | External byte offered |
| rxByte | input | 8 | External byte |
| rxFull | output | 1 | Receive queue holds 64 bytes |
| irqPulse | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume the host never raises wrEn and rdEn in the same cycle. Under that assumption each cycle decodes to at most one register strobe. They also assume all inputs are held at zero during reset, so that no past strobe value exists before the first real access. The bench applies each access from a task that drives one strobe at a falling edge and drops it at the next falling edge. It only offers external bytes between host accesses, so every assumption holds throughout the run.

// File: rtl/serial_regbank_pkg.sv
package serial_regbank_pkg;

  localparam int BYTE_W = 8;

  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_IER  = 3'd1;
  localparam logic [2:0] OFF_IIR  = 3'd2;
  localparam logic [2:0] OFF_LCR  = 3'd3;
  localparam logic [2:0] OFF_MCR  = 3'd4;
  localparam logic [2:0] OFF_LSR  = 3'd5;
  localparam logic [2:0] OFF_MSR  = 3'd6;
  localparam logic [2:0] OFF_SCR  = 3'd7;

  localparam int LCR_BANK_BIT = 7;
  localparam int MCR_LOOP_BIT = 4;
  localparam int IER_RX_BIT   = 0;
  localparam int IER_TX_BIT   = 1;

  localparam logic [7:0] IIR_IDLE   = 8'h01;
  localparam logic [7:0] IIR_RDMASK = 8'hC0;
  localparam logic [7:0] LSR_BASE   = 8'h60;
  localparam logic [7:0] MSR_FIXED  = 8'hB0;
  localparam logic [7:0] LCR_INIT   = 8'h03;
  localparam logic [7:0] MCR_INIT   = 8'h08;

  typedef struct packed {
    logic wrData;
    logic wrIer;
    logic wrLcr;
    logic wrMcr;
    logic wrScr;
    logic wrDivLo;
    logic wrDivHi;
    logic rdData;
    logic rdIir;
  } ctrlStrobe_t;

endpackage

// File: rtl/serial_regbank_ctrl.sv
module serial_regbank_ctrl
  import serial_regbank_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regAddr,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        bankSel,
  output ctrlStrobe_t strb
);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      unique case (regAddr)
        OFF_DATA: if (bankSel) strb.wrDivLo = 1'b1; else strb.wrData = 1'b1;
        OFF_IER:  if (bankSel) strb.wrDivHi = 1'b1; else strb.wrIer = 1'b1;
        OFF_LCR:  strb.wrLcr = 1'b1;
        OFF_MCR:  strb.wrMcr = 1'b1;
        OFF_SCR:  strb.wrScr = 1'b1;
        default:  ;
      endcase
    end else if (rdEn) begin
      if (regAddr == OFF_DATA && !bankSel) strb.rdData = 1'b1;
      if (regAddr == OFF_IIR) strb.rdIir = 1'b1;
    end
  end

  // R2: a single host access decodes to at most one register strobe
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && rdEn) |-> $onehot0(strb));

  // R11: writes to read-only offsets raise no strobe
  assert_ro_nowrite_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (regAddr == OFF_IIR || regAddr == OFF_LSR || regAddr == OFF_MSR)) |-> (strb == '0));

endmodule

// File: rtl/serial_regbank_fifo.sv
module serial_regbank_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             full,
  output logic             empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic pushOk, popOk;

  assign full     = (count == FULL_CNT);
  assign empty    = (count == '0);
  assign pushOk   = push && !full;
  assign popOk    = pop && !empty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  // R10: occupancy never exceeds the queue depth
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R10: a push into a full queue without a pop leaves it full
  assert_full_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> full);

endmodule

// File: rtl/serial_regbank_dp.sv
module serial_regbank_dp
  import serial_regbank_pkg::*;
#(
  parameter int          DEPTH     = 64,
  parameter logic [15:0] DIV_RESET = 16'd12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [2:0]        regAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  output logic [BYTE_W-1:0] rdData,
  output logic              bankSel,
  output logic              txValid,
  output logic [BYTE_W-1:0] txByte,
  output logic              rxFull,
  output logic              irqPulse
);

  logic [7:0]  lcrReg, mcrReg, ierReg, scrReg;
  logic [15:0] divReg;
  logic        iirTx, iirRx;
  logic        loopOn, fifoPush, fifoFull, fifoEmpty, pushAccepted;
  logic        txFire, txSet, rxSet;
  logic [7:0]  fifoIn, fifoHead, iirVal, lsrVal;

  assign bankSel = lcrReg[LCR_BANK_BIT];
  assign loopOn  = mcrReg[MCR_LOOP_BIT];
  assign rxFull  = fifoFull;

  assign fifoPush     = loopOn ? strb.wrData : rxValid;
  assign fifoIn       = loopOn ? wrData : rxByte;
  assign pushAccepted = fifoPush && !fifoFull;
  assign txFire       = strb.wrData && !loopOn;
  assign txSet        = txFire && ierReg[IER_TX_BIT];
  assign rxSet        = pushAccepted && ierReg[IER_RX_BIT];

  serial_regbank_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) rxq_i (
    .clk      (clk),
    .rstN     (rstN),
    .push     (fifoPush),
    .pushData (fifoIn),
    .pop      (strb.rdData),
    .headData (fifoHead),
    .full     (fifoFull),
    .empty    (fifoEmpty)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lcrReg <= LCR_INIT;
      mcrReg <= MCR_INIT;
      ierReg <= '0;
      scrReg <= '0;
      divReg <= DIV_RESET;
    end else begin
      if (strb.wrLcr)   lcrReg <= wrData;
      if (strb.wrMcr)   mcrReg <= wrData;
      if (strb.wrIer)   ierReg <= {4'b0000, wrData[3:0]};
      if (strb.wrScr)   scrReg <= wrData;
      if (strb.wrDivLo) divReg[7:0]  <= wrData;
      if (strb.wrDivHi) divReg[15:8] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iirTx <= 1'b0;
      iirRx <= 1'b0;
    end else begin
      if (txSet)            iirTx <= 1'b1;
      else if (strb.rdIir)  iirTx <= 1'b0;
      if (rxSet)                           iirRx <= 1'b1;
      else if (strb.rdIir || strb.rdData)  iirRx <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid  <= 1'b0;
      txByte   <= '0;
      irqPulse <= 1'b0;
    end else begin
      txValid  <= txFire;
      if (txFire) txByte <= wrData;
      irqPulse <= txSet || rxSet;
    end
  end

  assign iirVal = {5'b00000, iirRx, iirTx, !(iirRx || iirTx)};
  assign lsrVal = LSR_BASE | {7'b0000000, !fifoEmpty};

  always_comb begin
    unique case (regAddr)
      OFF_DATA: rdData = bankSel ? divReg[7:0] : (fifoEmpty ? 8'h00 : fifoHead);
      OFF_IER:  rdData = bankSel ? divReg[15:8] : ierReg;
      OFF_IIR:  rdData = iirVal | IIR_RDMASK;
      OFF_LCR:  rdData = lcrReg;
      OFF_MCR:  rdData = mcrReg;
      OFF_LSR:  rdData = lsrVal;
      OFF_MSR:  rdData = MSR_FIXED;
      OFF_SCR:  rdData = scrReg;
      default:  rdData = 8'h00;
    endcase
  end

  // R3: upper enable bits never become set
  assert_ier_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    ierReg[7:4] == 4'h0);

  // R4: an identification read with no new event leaves the idle code
  assert_iir_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdIir && !txSet && !rxSet) |=> (iirVal == IIR_IDLE));

  // R8: loopback writes never reach the transmit strobe
  assert_loop_no_tx_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrData && loopOn) |=> !txValid);

  // R10: a full queue always reports data ready
  assert_full_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
    rxFull |-> lsrVal[0]);

  // R9: external bytes in loopback leave the queue unchanged when nothing else pushes
  assert_loop_ignore_R9: assert property (@(posedge clk) disable iff (!rstN)
    (loopOn && rxValid && !strb.wrData && !strb.rdData) |=> $stable(fifoEmpty));

endmodule

// File: rtl/serial_regbank.sv
module serial_regbank
  import serial_regbank_pkg::*;
#(
  parameter int          DEPTH     = 64,
  parameter logic [15:0] DIV_RESET = 16'd12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regAddr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       rdEn,
  output logic [7:0] rdData,
  output logic       txValid,
  output logic [7:0] txByte,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  output logic       rxFull,
  output logic       irqPulse
);

  ctrlStrobe_t strb;
  logic        bankSel;

  serial_regbank_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .bankSel (bankSel),
    .strb    (strb)
  );

  serial_regbank_dp #(.DEPTH(DEPTH), .DIV_RESET(DIV_RESET)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regAddr  (regAddr),
    .wrData   (wrData),
    .rxValid  (rxValid),
    .rxByte   (rxByte),
    .rdData   (rdData),
    .bankSel  (bankSel),
    .txValid  (txValid),
    .txByte   (txByte),
    .rxFull   (rxFull),
    .irqPulse (irqPulse)
  );

endmodule

// File: tb/serial_regbank_tb_top.sv
module serial_regbank_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       txValid;
  logic [7:0] txByte;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic       rxFull;
  logic       irqPulse;

  int nChecks = 0;
  int nFails  = 0;
  logic       gotTx, gotIrq;
  logic [7:0] gotTxByte;

  always #10 clk = ~clk;

  serial_regbank dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .txValid(txValid), .txByte(txByte),
    .rxValid(rxValid), .rxByte(rxByte), .rxFull(rxFull), .irqPulse(irqPulse)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    gotTx = txValid; gotTxByte = txByte; gotIrq = irqPulse;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
    gotIrq = irqPulse;
  endtask

  task automatic rxOffer(input logic [7:0] b);
    @(negedge clk);
    rxByte = b; rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
    gotIrq = irqPulse;
  endtask

  task automatic expectRead(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    regRead(a, v);
    check(req, v, exp);
  endtask

  task automatic testReset();
    check("R1 txValid", {7'b0, txValid}, 8'h00);
    check("R1 irqPulse", {7'b0, irqPulse}, 8'h00);
    check("R1 rxFull", {7'b0, rxFull}, 8'h00);
    expectRead("R1 data", 3'd0, 8'h00);
    expectRead("R1 ier", 3'd1, 8'h00);
    expectRead("R1 iir", 3'd2, 8'hC1);
    expectRead("R1 lcr", 3'd3, 8'h03);
    expectRead("R1 mcr", 3'd4, 8'h08);
    expectRead("R1 lsr", 3'd5, 8'h60);
    expectRead("R1 msr", 3'd6, 8'hB0);
    expectRead("R1 scr", 3'd7, 8'h00);
  endtask

  task automatic testDivisor();
    regWrite(3'd3, 8'h83);
    expectRead("R1 div lo reset", 3'd0, 8'h0C);
    expectRead("R1 div hi reset", 3'd1, 8'h00);
    regWrite(3'd0, 8'h12);
    regWrite(3'd1, 8'h34);
    check("R2 no tx when banked", {7'b0, gotTx}, 8'h00);
    expectRead("R2 div lo", 3'd0, 8'h12);
    expectRead("R2 div hi", 3'd1, 8'h34);
    expectRead("R12 lcr", 3'd3, 8'h83);
    regWrite(3'd3, 8'h03);
    expectRead("R2 ier untouched", 3'd1, 8'h00);
    expectRead("R2 data untouched", 3'd0, 8'h00);
    regWrite(3'd1, 8'hFF);
    expectRead("R3 ier mask", 3'd1, 8'h0F);
    regWrite(3'd1, 8'h00);
    regWrite(3'd3, 8'h80);
    expectRead("R2 div kept", 3'd0, 8'h12);
    regWrite(3'd3, 8'h03);
  endtask

  task automatic testTx();
    regWrite(3'd1, 8'h02);
    regWrite(3'd0, 8'h41);
    check("R5 txValid", {7'b0, gotTx}, 8'h01);
    check("R5 txByte", gotTxByte, 8'h41);
    check("R5 irq", {7'b0, gotIrq}, 8'h01);
    @(negedge clk);
    check("R13 irq one cycle", {7'b0, irqPulse}, 8'h00);
    check("R5 tx one cycle", {7'b0, txValid}, 8'h00);
    expectRead("R4 iir tx", 3'd2, 8'hC2);
    expectRead("R4 iir cleared", 3'd2, 8'hC1);
    regWrite(3'd1, 8'h00);
    regWrite(3'd0, 8'h42);
    check("R5 txByte no irq", gotTxByte, 8'h42);
    check("R5 no irq when disabled", {7'b0, gotIrq}, 8'h00);
    expectRead("R4 iir idle", 3'd2, 8'hC1);
  endtask

  task automatic testRx();
    regWrite(3'd1, 8'h01);
    rxOffer(8'hA1);
    check("R6 irq", {7'b0, gotIrq}, 8'h01);
    rxOffer(8'hA2);
    rxOffer(8'hA3);
    expectRead("R6 lsr ready", 3'd5, 8'h61);
    regWrite(3'd1, 8'h03);
    regWrite(3'd0, 8'h55);
    check("R5 irq with rx enabled", {7'b0, gotIrq}, 8'h01);
    expectRead("R7 fifo order 1", 3'd0, 8'hA1);
    expectRead("R4 fallback to tx", 3'd2, 8'hC2);
    expectRead("R7 fifo order 2", 3'd0, 8'hA2);
    expectRead("R7 lsr still ready", 3'd5, 8'h61);
    expectRead("R7 fifo order 3", 3'd0, 8'hA3);
    expectRead("R7 lsr empty", 3'd5, 8'h60);
    expectRead("R7 empty read", 3'd0, 8'h00);
    regWrite(3'd1, 8'h00);
  endtask

  task automatic testReadOnly();
    regWrite(3'd5, 8'hFF);
    regWrite(3'd6, 8'h00);
    regWrite(3'd2, 8'hFF);
    expectRead("R11 lsr", 3'd5, 8'h60);
    expectRead("R11 msr", 3'd6, 8'hB0);
    expectRead("R11 iir", 3'd2, 8'hC1);
    regWrite(3'd7, 8'h5A);
    expectRead("R12 scr", 3'd7, 8'h5A);
  endtask

  task automatic testLoop();
    regWrite(3'd4, 8'h18);
    expectRead("R12 mcr", 3'd4, 8'h18);
    regWrite(3'd0, 8'h11);
    check("R8 no tx in loop", {7'b0, gotTx}, 8'h00);
    regWrite(3'd0, 8'h22);
    rxOffer(8'h99);
    expectRead("R8 lsr ready", 3'd5, 8'h61);
    expectRead("R8 loop byte 1", 3'd0, 8'h11);
    expectRead("R8 loop byte 2", 3'd0, 8'h22);
    expectRead("R9 external ignored", 3'd0, 8'h00);
    for (int i = 0; i < 66; i++) regWrite(3'd0, 8'(i));
    check("R8 full after 64", {7'b0, rxFull}, 8'h01);
    for (int i = 0; i < 64; i++) expectRead("R8 loop fill order", 3'd0, 8'(i));
    expectRead("R8 overflow dropped", 3'd0, 8'h00);
    regWrite(3'd4, 8'h08);
  endtask

  task automatic testFull();
    for (int i = 0; i < 64; i++) rxOffer(8'(8'h80 + i));
    check("R10 rxFull set", {7'b0, rxFull}, 8'h01);
    rxOffer(8'hEE);
    check("R10 rxFull held", {7'b0, rxFull}, 8'h01);
    expectRead("R10 first byte", 3'd0, 8'h80);
    check("R10 rxFull cleared", {7'b0, rxFull}, 8'h00);
    for (int i = 1; i < 64; i++) expectRead("R10 order", 3'd0, 8'(8'h80 + i));
    expectRead("R10 extra dropped", 3'd0, 8'h00);
    expectRead("R7 lsr after drain", 3'd5, 8'h60);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDivisor();
    testTx();
    testRx();
    testReadOnly();
    testLoop();
    testFull();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule